// File: doc/BRIEF.md
# Zero-Stuffing Interpolator with Mirrored Tap Window

This block takes signed I/Q samples that arrive in groups of eight per range cell, with four idle input slots after each group. It doubles the sample rate by pushing a zero into the stream after every real sample. The doubled stream moves through a fifteen-entry register window. For every shift of the window, the block presents eight mirrored tap pairs around the window's midpoint, one pair per pair slot. The bilinear kernel stage that follows uses these pairs. That stage multiplies the first tap by the conjugate of the second; negating Q is its job, not this block's.

Everything runs on one clock. An internal strobe generator stands in for the divided clocks. It raises a pair strobe every `PAIR_DIV` clocks. A window shift takes eight pair strobes, and an input slot takes two shifts, so the input, shift and pair rates stand at 1:2:16. The block tells the sample source when a sample is consumed through `in_take`. The source holds each sample on the inputs until `in_take` has been high for one cycle. At the first sample of each group, the interpolation phase starts on a real sample and every older window entry is cleared.

Top module: `zsw_interp_window`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pair_valid`, `last_pair` and `in_take` are 0. After reset, `pair_k` and all four tap outputs are 0.
- R2: `pair_valid` pulses for one cycle once every `PAIR_DIV` clocks. `pair_k` counts 0 to 7 and wraps over successive pulses. `last_pair` is 1 exactly on the pulse with `pair_k` = 7.
- R3: `in_take` is high for one cycle per sixteen pair slots, on the cycle in which the strobe for the pair with index 7 is raised. Within each 12-slot input period it is high only in the first 8 slots, and the window shift that follows, in the next cycle, is marked by a pulse with `last_pair` = 1.
- R4: Between two accepted samples, exactly one zero enters the window. The window shift after a taken sample loads that sample at window index 0 (the newest entry). The next shift loads a zero.
- R5: During the 4 idle input slots, zeros enter the window. Input values are ignored whenever `in_take` is low.
- R6: On the shift that takes the first sample of a group, window entries 1 to 14 are cleared to 0.
- R7: In the window, index 0 is the newest entry and the midpoint is index 7. The pulse with `pair_k` = k carries entry 7-k on `lead_i`/`lead_q` and entry 7+k on `lag_i`/`lag_q`. For k = 0, both outputs carry the midpoint.
- R8: All eight pairs of one shift period are read from the same window contents. The window shifts only after the pair with index 7 has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| in_i | input | 8 | Signed in-phase sample, held until taken |
| in_q | input | 8 | Signed quadrature sample, held until taken |
| in_take | output | 1 | High in the cycle the presented sample is consumed |
| pair_valid | output | 1 | One-cycle strobe marking a new tap pair |
| pair_k | output | 3 | Mirror distance of the current pair |
| last_pair | output | 1 | Marks the pair with distance 7 |
| lead_i | output | 8 | I of the tap k entries newer than the midpoint |
| lead_q | output | 8 | Q of the tap k entries newer than the midpoint |
| lag_i | output | 8 | I of the tap k entries older than the midpoint |
| lag_q | output | 8 | Q of the tap k entries older than the midpoint |

## Verification
The bench builds the block with `PAIR_DIV` = 2, so idle cycles separate the pair strobes. This exposes any output that changes outside a strobe, or any window shift that happens without a strobe. The default window depth and group shape are kept, so several full groups run within a short time. The idle slots and the stuffed-zero phases get random nonzero input values, which a design that wrongly sampled the inputs would carry into its taps. A reset applied in the middle of the run checks that the strobe sequence restarts cleanly at a group boundary.

// File: rtl/zsw_pkg.sv
package zsw_pkg;

    localparam int SMP_W = 8;

    typedef struct packed {
        logic signed [SMP_W-1:0] i;
        logic signed [SMP_W-1:0] q;
    } iq_t;

    typedef enum logic {
        PH_SAMPLE = 1'b0,
        PH_STUFF  = 1'b1
    } phase_e;

    function automatic iq_t iq_join(input logic [SMP_W-1:0] i_v,
                                    input logic [SMP_W-1:0] q_v);
        iq_t r;
        r.i = i_v;
        r.q = q_v;
        return r;
    endfunction

endpackage

// File: rtl/zsw_sequencer.sv
module zsw_sequencer
    import zsw_pkg::*;
#(
    parameter int NPAIR      = 8,
    parameter int GROUP_LEN  = 8,
    parameter int IDLE_SLOTS = 4,
    parameter int PAIR_DIV   = 1,
    localparam int K_W       = (NPAIR > 1) ? $clog2(NPAIR) : 1,
    localparam int SLOTS     = GROUP_LEN + IDLE_SLOTS,
    localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic           clk,
    input  logic           rst,
    output logic           tick,
    output logic [K_W-1:0] k,
    output logic           shift_now,
    output logic           take,
    output logic           clear
);

    localparam logic [K_W-1:0]    K_LAST    = K_W'(NPAIR - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] GRP_END   = SLOT_W'(GROUP_LEN);

    phase_e            phase;
    logic [SLOT_W-1:0] slot;

    generate
        if (PAIR_DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DIV_W = $clog2(PAIR_DIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PAIR_DIV - 1);
            logic [DIV_W-1:0] divcnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    divcnt <= '0;
                end else if (divcnt == DIV_LAST) begin
                    divcnt <= '0;
                end else begin
                    divcnt <= divcnt + 1'b1;
                end
            end
            assign tick = (divcnt == DIV_LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            k     <= '0;
            phase <= PH_SAMPLE;
            slot  <= '0;
        end else if (tick) begin
            if (k == K_LAST) begin
                k <= '0;
                if (phase == PH_STUFF) begin
                    phase <= PH_SAMPLE;
                    slot  <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
                end else begin
                    phase <= PH_STUFF;
                end
            end else begin
                k <= k + 1'b1;
            end
        end
    end

    assign shift_now = tick && (k == K_LAST);
    assign take      = shift_now && (phase == PH_SAMPLE) && (slot < GRP_END);
    assign clear     = shift_now && (phase == PH_SAMPLE) && (slot == '0);

endmodule

// File: rtl/zsw_window.sv
module zsw_window
    import zsw_pkg::*;
#(
    parameter int TAPS = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_now,
    input  logic              take,
    input  logic              clear,
    input  iq_t               din,
    output iq_t [TAPS-1:0]    taps
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps[0] <= '0;
        end else if (shift_now) begin
            taps[0] <= take ? din : '0;
        end
    end

    generate
        for (genvar j = 1; j < TAPS; j++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    taps[j] <= '0;
                end else if (shift_now) begin
                    taps[j] <= clear ? '0 : taps[j-1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/zsw_tap_select.sv
module zsw_tap_select
    import zsw_pkg::*;
#(
    parameter int TAPS   = 15,
    localparam int MID   = (TAPS - 1) / 2,
    localparam int NPAIR = MID + 1,
    localparam int K_W   = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [K_W-1:0]  k,
    input  iq_t [TAPS-1:0]  taps,
    output logic            pair_valid,
    output logic [K_W-1:0]  pair_k,
    output logic            last_pair,
    output iq_t             lead,
    output iq_t             lag
);

    iq_t lead_c, lag_c;

    always_comb begin
        lead_c = '0;
        lag_c  = '0;
        for (int j = 0; j < NPAIR; j++) begin
            if (k == K_W'(j)) begin
                lead_c = taps[MID-j];
                lag_c  = taps[MID+j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_valid <= 1'b0;
            last_pair  <= 1'b0;
            pair_k     <= '0;
            lead       <= '0;
            lag        <= '0;
        end else begin
            pair_valid <= tick;
            last_pair  <= tick && (k == K_W'(NPAIR - 1));
            if (tick) begin
                pair_k <= k;
                lead   <= lead_c;
                lag    <= lag_c;
            end
        end
    end

endmodule

// File: rtl/zsw_interp_window.sv
module zsw_interp_window
    import zsw_pkg::*;
#(
    parameter int TAPS       = 15,
    parameter int GROUP_LEN  = 8,
    parameter int IDLE_SLOTS = 4,
    parameter int PAIR_DIV   = 1,
    localparam int NPAIR     = (TAPS + 1) / 2,
    localparam int K_W       = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] in_i,
    input  logic signed [SMP_W-1:0] in_q,
    output logic                    in_take,
    output logic                    pair_valid,
    output logic [K_W-1:0]          pair_k,
    output logic                    last_pair,
    output logic signed [SMP_W-1:0] lead_i,
    output logic signed [SMP_W-1:0] lead_q,
    output logic signed [SMP_W-1:0] lag_i,
    output logic signed [SMP_W-1:0] lag_q
);

    logic           tick, shift_now, take, clear;
    logic [K_W-1:0] k;
    iq_t [TAPS-1:0] taps;
    iq_t            lead, lag;

    zsw_sequencer #(
        .NPAIR(NPAIR), .GROUP_LEN(GROUP_LEN),
        .IDLE_SLOTS(IDLE_SLOTS), .PAIR_DIV(PAIR_DIV)
    ) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .k(k),
        .shift_now(shift_now), .take(take), .clear(clear)
    );

    zsw_window #(.TAPS(TAPS)) u_win (
        .clk(clk), .rst(rst), .shift_now(shift_now), .take(take),
        .clear(clear), .din(iq_join(in_i, in_q)), .taps(taps)
    );

    zsw_tap_select #(.TAPS(TAPS)) u_sel (
        .clk(clk), .rst(rst), .tick(tick), .k(k), .taps(taps),
        .pair_valid(pair_valid), .pair_k(pair_k), .last_pair(last_pair),
        .lead(lead), .lag(lag)
    );

    assign in_take = take;
    assign lead_i  = lead.i;
    assign lead_q  = lead.q;
    assign lag_i   = lag.i;
    assign lag_q   = lag.q;

endmodule

// File: rtl/zsw_checker.sv
module zsw_checker #(
    parameter int K_W = 3,
    parameter int W   = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           in_take,
    input logic           pair_valid,
    input logic [K_W-1:0] pair_k,
    input logic           last_pair,
    input logic [W-1:0]   lead_i,
    input logic [W-1:0]   lead_q,
    input logic [W-1:0]   lag_i,
    input logic [W-1:0]   lag_q
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!pair_valid && !last_pair && !in_take));

    // R2
    last_marks_top_chk: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> (last_pair == (pair_k == {K_W{1'b1}})));

    // R2
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        last_pair |-> pair_valid);

    // R3
    take_then_last_chk: assert property (@(posedge clk) disable iff (rst)
        in_take |=> (pair_valid && last_pair));

    // R7
    mid_pair_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_valid && pair_k == '0) |-> (lead_i == lag_i && lead_q == lag_q));

endmodule

bind zsw_interp_window zsw_checker #(.K_W(K_W), .W(zsw_pkg::SMP_W)) u_chk (
    .clk(clk), .rst(rst), .in_take(in_take), .pair_valid(pair_valid),
    .pair_k(pair_k), .last_pair(last_pair), .lead_i(lead_i),
    .lead_q(lead_q), .lag_i(lag_i), .lag_q(lag_q)
);

// File: tb/zsw_interp_window_test.sv
`timescale 1ns/1ps
module zsw_interp_window_test;

    localparam int PD = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [7:0] in_i = '0, in_q = '0;
    logic in_take, pair_valid, last_pair;
    logic [2:0] pair_k;
    logic signed [7:0] lead_i, lead_q, lag_i, lag_q;

    always #2.5 clk = ~clk;

    zsw_interp_window #(.PAIR_DIV(PD)) uut (
        .clk(clk), .rst(rst), .in_i(in_i), .in_q(in_q), .in_take(in_take),
        .pair_valid(pair_valid), .pair_k(pair_k), .last_pair(last_pair),
        .lead_i(lead_i), .lead_q(lead_q), .lag_i(lag_i), .lag_q(lag_q)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // behavioural reference
    int n, t;
    int wi[15], wq[15];
    int ev, el, ek, eli, elq, egi, egq;

    always @(posedge clk) begin
        if (rst) begin
            n = 0; t = 0;
            for (int j = 0; j < 15; j++) begin wi[j] = 0; wq[j] = 0; end
            ev = 0; el = 0; ek = 0; eli = 0; elq = 0; egi = 0; egq = 0;
        end else begin
            ev = 0; el = 0;
            if (n % PD == PD - 1) begin
                int kk, s, ph, sl;
                kk = t % 8; s = t / 8; ph = s % 2; sl = (s / 2) % 12;
                ev = 1; ek = kk; el = (kk == 7);
                eli = wi[7-kk]; elq = wq[7-kk];
                egi = wi[7+kk]; egq = wq[7+kk];
                if (kk == 7) begin
                    if (ph == 0 && sl == 0)
                        for (int j = 0; j < 15; j++) begin wi[j] = 0; wq[j] = 0; end
                    for (int j = 14; j > 0; j--) begin wi[j] = wi[j-1]; wq[j] = wq[j-1]; end
                    wi[0] = (ph == 0 && sl < 8) ? int'(in_i) : 0;
                    wq[0] = (ph == 0 && sl < 8) ? int'(in_q) : 0;
                end
                t++;
            end
            n++;
        end
    end

    function automatic int exp_take();
        int s;
        s = t / 8;
        return (!rst && (n % PD == PD - 1) && (t % 8 == 7) && (s % 2 == 0)
                && ((s / 2) % 12 < 8)) ? 1 : 0;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic compare_all();
        string r;
        r = (rst || n == 0) ? "R1" : "R2";
        check({r, " pair_valid"}, int'(pair_valid), ev);
        check({r, " last_pair"}, int'(last_pair), el);
        check({r, " pair_k"}, int'(pair_k), ek);
        check((rst || n == 0) ? "R1 in_take" : "R3 in_take", int'(in_take), exp_take());
        check("R4 R5 R6 R7 R8 lead_i", int'(lead_i), eli);
        check("R4 R5 R6 R7 R8 lead_q", int'(lead_q), elq);
        check("R4 R5 R6 R7 R8 lag_i", int'(lag_i), egi);
        check("R4 R5 R6 R7 R8 lag_q", int'(lag_q), egq);
    endtask

    task automatic drive_rand();
        int sel;
        sel = $urandom_range(0, 9);
        if (sel == 0) begin in_i = 8'sh80; in_q = 8'sh7f; end
        else if (sel == 1) begin in_i = 8'sh7f; in_q = 8'sh80; end
        else begin in_i = 8'($urandom); in_q = 8'($urandom); end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare_all();
        rst = 1'b0;
        for (int c = 0; c < 1300; c++) begin
            @(negedge clk);
            compare_all();
            if (in_take || ($urandom_range(0, 3) == 0)) drive_rand();
        end
        rst = 1'b1;
        repeat (2) @(negedge clk);
        compare_all();
        rst = 1'b0;
        for (int c = 0; c < 900; c++) begin
            @(negedge clk);
            compare_all();
            if (in_take || ($urandom_range(0, 3) == 0)) drive_rand();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule